// File: doc/BRIEF.md
# Glitch-free GPIO bank restore sequencer

After a low-power state, a GPIO bank has to get back its saved configuration, data and pull-up words. If the configuration is written first, a pin that turns into an output can briefly drive stale data. If the data is written first, a pin that is leaving output mode can briefly drive the new value. This sequencer avoids both. It reads the bank's current configuration word and compares it with the saved word one pin at a time. Pins whose change is safe before the data exists get their new configuration in an early write. The data word follows. Then the complete saved configuration is written, and last the pull-up word.

The block drives a single-outstanding register master port. That port has a read request with a valid response and a write request that waits on a ready signal. A start/done handshake sequences one bank per request. A per-request flag selects the narrow bank variant, which has one configuration bit per pin and no pull-up register. The saved words and the bank flag are sampled when a request is accepted.

Top module: `gpio_bank_restorer`

## Requirements
- R1: While reset is active and after it is released with no request, `busy`, `done`, `rd_en` and `wr_en` are all 0.
- R2: An accepted request issues exactly one read of the configuration address, before any write. `rd_en` stays high until `rd_valid` is seen.
- R3: For a normal bank (`bank_bitwise`=0) exactly four writes occur, to the configuration, data, configuration and pull-up addresses, in that order.
- R4: In a normal bank, pin p's field sits at bits 2p+1:2p and is encoded 0 = input, 1 = output, 2 or 3 = special function. The first configuration write takes the saved field for pins going input→special, output→special, output→input or special→input. Every other pin keeps its current field.
- R5: The second, third and fourth writes of a normal bank carry the saved data, the saved configuration and the saved pull-up word.
- R6: For the narrow bank (`bank_bitwise`=1; 1 bit per pin, 0 = output, 1 = special) exactly three writes occur: current OR saved configuration to the configuration address, the saved data to the data address, then the saved configuration. No write goes to the pull-up address.
- R7: A write whose `wr_ready` is low keeps `wr_en`, `wr_addr` and `wr_data` unchanged in the next cycle. The next write starts only after acceptance.
- R8: `done` is high for exactly one cycle, the cycle right after the last accepted write.
- R9: A `start` seen while `busy` is high is ignored and causes no extra read, write or done.
- R10: The saved words and `bank_bitwise` are taken when the request is accepted. Changing them later does not affect the writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to restore one bank |
| bank_bitwise | input | 1 | 1 selects the one-bit-per-pin bank without pull-ups |
| saved_cfg | input | WORD_W | Saved configuration word |
| saved_dat | input | WORD_W | Saved data word |
| saved_pull | input | WORD_W | Saved pull-up word |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_en | output | 1 | Read request |
| rd_addr | output | ADDR_W | Read address (configuration register) |
| rd_data | input | WORD_W | Read response data |
| rd_valid | input | 1 | Read response valid |
| wr_en | output | 1 | Write request |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | WORD_W | Write data |
| wr_ready | input | 1 | Write accepted this cycle |

## Verification
The main stimulus is a rotating sweep. For each run the sixteen pins hold every one of the sixteen old/new field pairs, and the pattern is shifted across all sixteen positions. This separates the four early transitions from the two deferred ones and from the unchanged pairs, in every bit position. Random words with random handshake stalls then test the write ordering and the holding of stalled writes. Narrow-bank runs show the OR merge and the missing pull-up write. In every run the saved inputs are scrambled after acceptance, and some runs also pulse `start` mid-sequence, which separates captured values from live ones and shows that a start during a busy request is ignored.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_EARLY,
      ST_DATA,
      ST_FULL,
      ST_PULL,
      ST_DONE
   } gpr_state_e;

   localparam logic [1:0] FLD_OUT = 2'd1;

   function automatic logic fld_is_special(input logic [1:0] f);
      return f[1];
   endfunction
endpackage

// File: rtl/gpr_early_mask.sv
module gpr_early_mask #(
   parameter int WORD_W = 32
) (
   input  logic [WORD_W-1:0] old_cfg,
   input  logic [WORD_W-1:0] new_cfg,
   output logic [WORD_W-1:0] early_mask
);
   import gpr_pkg::*;

   localparam int FIELD_W = 2;
   localparam int PINS    = WORD_W / FIELD_W;

   for (genvar p = 0; p < PINS; p++) begin : g_pin
      logic [FIELD_W-1:0] f_old;
      logic [FIELD_W-1:0] f_new;
      logic               hit;
      assign f_old = old_cfg[p*FIELD_W +: FIELD_W];
      assign f_new = new_cfg[p*FIELD_W +: FIELD_W];
      // differs, not special->special, and not heading into output mode
      assign hit = (f_old != f_new)
                   && !(fld_is_special(f_old) && fld_is_special(f_new))
                   && (f_new != FLD_OUT);
      assign early_mask[p*FIELD_W +: FIELD_W] = {FIELD_W{hit}};
   end
endmodule

// File: rtl/gpr_seq_ctrl.sv
module gpr_seq_ctrl (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                bitwise_q,
   input  logic                rd_valid,
   input  logic                wr_ready,
   output gpr_pkg::gpr_state_e state,
   output logic                accept
);
   import gpr_pkg::*;

   gpr_state_e nxt;

   assign accept = (state == ST_IDLE) && start;

   always_comb begin
      nxt = state;
      case (state)
         ST_IDLE:  if (start)    nxt = ST_READ;
         ST_READ:  if (rd_valid) nxt = ST_EARLY;
         ST_EARLY: if (wr_ready) nxt = ST_DATA;
         ST_DATA:  if (wr_ready) nxt = ST_FULL;
         ST_FULL:  if (wr_ready) nxt = bitwise_q ? ST_DONE : ST_PULL;
         ST_PULL:  if (wr_ready) nxt = ST_DONE;
         ST_DONE:                nxt = ST_IDLE;
         default:                nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end
endmodule

// File: rtl/gpio_bank_restorer.sv
module gpio_bank_restorer #(
   parameter int              WORD_W          = 32,
   parameter int              ADDR_W          = 8,
   parameter logic [ADDR_W-1:0] CFG_OFS       = 8'h00,
   parameter logic [ADDR_W-1:0] DAT_OFS       = 8'h04,
   parameter logic [ADDR_W-1:0] PULL_OFS      = 8'h08,
   parameter bit              SUPPORT_BITWISE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              bank_bitwise,
   input  logic [WORD_W-1:0] saved_cfg,
   input  logic [WORD_W-1:0] saved_dat,
   input  logic [WORD_W-1:0] saved_pull,
   output logic              busy,
   output logic              done,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [WORD_W-1:0] rd_data,
   input  logic              rd_valid,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [WORD_W-1:0] wr_data,
   input  logic              wr_ready
);
   import gpr_pkg::*;

   if (WORD_W % 2 != 0) begin : g_bad_width
      $error("WORD_W must hold whole two-bit pin fields");
   end
   if (CFG_OFS == DAT_OFS || CFG_OFS == PULL_OFS || DAT_OFS == PULL_OFS) begin : g_bad_addr
      $error("register offsets must be distinct");
   end

   gpr_state_e        state;
   logic              accept;
   logic              bitwise_q;
   logic [WORD_W-1:0] cfg_q, dat_q, pull_q, old_q;
   logic [WORD_W-1:0] early_mask;
   logic [WORD_W-1:0] merged_word;
   logic [WORD_W-1:0] first_word;

   gpr_seq_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .bitwise_q (bitwise_q),
      .rd_valid  (rd_valid),
      .wr_ready  (wr_ready),
      .state     (state),
      .accept    (accept)
   );

   gpr_early_mask #(.WORD_W(WORD_W)) u_mask (
      .old_cfg    (old_q),
      .new_cfg    (cfg_q),
      .early_mask (early_mask)
   );

   assign merged_word = (old_q & ~early_mask) | (cfg_q & early_mask);

   // capture request words
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         dat_q  <= '0;
         pull_q <= '0;
         old_q  <= '0;
      end else begin
         if (accept) begin
            cfg_q  <= saved_cfg;
            dat_q  <= saved_dat;
            pull_q <= saved_pull;
         end
         if (state == ST_READ && rd_valid) old_q <= rd_data;
      end
   end

   if (SUPPORT_BITWISE) begin : g_bitwise
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      bitwise_q <= 1'b0;
         else if (accept) bitwise_q <= bank_bitwise;
      end
      assign first_word = bitwise_q ? (old_q | cfg_q) : merged_word;
   end else begin : g_plain
      logic unused_flag;
      assign unused_flag = bank_bitwise;
      assign bitwise_q   = 1'b0;
      assign first_word  = merged_word;
   end

   assign busy    = (state != ST_IDLE);
   assign done    = (state == ST_DONE);
   assign rd_en   = (state == ST_READ);
   assign rd_addr = CFG_OFS;
   assign wr_en   = (state == ST_EARLY) || (state == ST_DATA)
                    || (state == ST_FULL) || (state == ST_PULL);

   always_comb begin
      wr_addr = CFG_OFS;
      wr_data = '0;
      case (state)
         ST_EARLY: wr_data = first_word;
         ST_DATA:  begin wr_addr = DAT_OFS;  wr_data = dat_q;  end
         ST_FULL:  wr_data = cfg_q;
         ST_PULL:  begin wr_addr = PULL_OFS; wr_data = pull_q; end
         default:  wr_data = '0;
      endcase
   end
endmodule

// File: rtl/gpr_restore_checker.sv
module gpr_restore_checker #(
   parameter int                WORD_W   = 32,
   parameter int                ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] CFG_OFS  = 8'h00,
   parameter logic [ADDR_W-1:0] PULL_OFS = 8'h08
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic              rd_en,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              rd_valid,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [WORD_W-1:0] wr_data,
   input logic              wr_ready,
   input logic              bitwise_q
);
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!wr_en && !rd_en && !done));

   assert_read_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !rd_valid) |=> rd_en);

   assert_read_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (rd_addr == CFG_OFS && !wr_en));

   assert_no_pull_narrow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && bitwise_q) |-> (wr_addr != PULL_OFS));

   assert_write_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_ready) |=> (wr_en && $stable(wr_addr) && $stable(wr_data)));

   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(wr_en && wr_ready));

   assert_start_launch_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
endmodule

bind gpio_bank_restorer gpr_restore_checker #(
   .WORD_W(WORD_W), .ADDR_W(ADDR_W), .CFG_OFS(CFG_OFS), .PULL_OFS(PULL_OFS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid),
   .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
   .bitwise_q(bitwise_q)
);

// File: tb/gpio_bank_restorer_bench.sv
module gpio_bank_restorer_bench;
   localparam int CLK_PERIOD = 10;
   localparam int W = 32;
   localparam int A = 8;
   localparam logic [A-1:0] CFG_A  = 8'h00;
   localparam logic [A-1:0] DAT_A  = 8'h04;
   localparam logic [A-1:0] PULL_A = 8'h08;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic bank_bitwise = 1'b0;
   logic [W-1:0] saved_cfg = '0, saved_dat = '0, saved_pull = '0;
   logic busy, done, rd_en, wr_en;
   logic [A-1:0] rd_addr, wr_addr;
   logic [W-1:0] rd_data, wr_data;
   logic rd_valid = 1'b0;
   logic wr_ready = 1'b0;

   gpio_bank_restorer #(.WORD_W(W), .ADDR_W(A), .CFG_OFS(CFG_A),
                        .DAT_OFS(DAT_A), .PULL_OFS(PULL_A)) u_gpio_bank_restorer (
      .clk(clk), .rst_n(rst_n), .start(start), .bank_bitwise(bank_bitwise),
      .saved_cfg(saved_cfg), .saved_dat(saved_dat), .saved_pull(saved_pull),
      .busy(busy), .done(done), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_data), .rd_valid(rd_valid), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_ready(wr_ready));

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, fails = 0;
   logic [W-1:0] cur_old = '0;
   assign rd_data = cur_old;

   // handshake responder
   logic [15:0] lfsr = 16'hACE1;
   bit stall_on = 1'b0;
   always @(negedge clk) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      wr_ready = stall_on ? lfsr[0] : 1'b1;
      rd_valid = rd_en && (stall_on ? lfsr[3] : 1'b1);
   end

   // monitor
   int cyc = 0, wcount = 0, rdcount = 0, donecnt = 0, last_wr_cyc = -10;
   int hold_err = 0, order_err = 0, done_err = 0, rd_addr_err = 0;
   logic [A-1:0] log_a [8];
   logic [W-1:0] log_d [8];
   bit hold_pend = 1'b0;
   logic [A-1:0] hold_a;
   logic [W-1:0] hold_d;
   always @(posedge clk) begin
      if (rst_n) begin
         if (hold_pend && (!wr_en || wr_addr != hold_a || wr_data != hold_d)) hold_err++;
         hold_pend = wr_en && !wr_ready;
         hold_a = wr_addr;
         hold_d = wr_data;
         if (rd_en && rd_valid) begin
            rdcount++;
            if (rd_addr != CFG_A) rd_addr_err++;
         end
         if (wr_en && wr_ready) begin
            if (wcount < 8) begin
               log_a[wcount] = wr_addr;
               log_d[wcount] = wr_data;
            end
            wcount++;
            last_wr_cyc = cyc;
            if (rdcount == 0) order_err++;
         end
         if (done) begin
            donecnt++;
            if (cyc != last_wr_cyc + 1) done_err++;
         end
      end
      cyc++;
   end

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [W-1:0] exp_first(input logic [W-1:0] o, input logic [W-1:0] n);
      logic [W-1:0] r;
      for (int i = 0; i < W/2; i++) begin
         logic [1:0] fo, fn;
         bit take;
         fo = o[2*i +: 2];
         fn = n[2*i +: 2];
         take = (fo == 2'd0 && fn >= 2'd2) || (fo == 2'd1 && fn >= 2'd2)
              || (fo == 2'd1 && fn == 2'd0) || (fo >= 2'd2 && fn == 2'd0);
         r[2*i +: 2] = take ? fn : fo;
      end
      return r;
   endfunction

   task automatic run_seq(input bit bw, input logic [W-1:0] oldc, input logic [W-1:0] scfg,
                          input logic [W-1:0] sdat, input logic [W-1:0] spull, input bit poke);
      int n, t;
      logic [A-1:0] ea [4];
      logic [W-1:0] ed [4];
      @(negedge clk);
      wcount = 0; rdcount = 0; donecnt = 0; hold_err = 0; order_err = 0;
      done_err = 0; rd_addr_err = 0;
      cur_old = oldc;
      bank_bitwise = bw; saved_cfg = scfg; saved_dat = sdat; saved_pull = spull;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      // R10: scramble the request inputs after acceptance
      bank_bitwise = ~bw; saved_cfg = ~scfg; saved_dat = sdat ^ 32'h5A5A_A5A5;
      saved_pull = ~spull;
      if (poke) begin
         @(negedge clk);
         @(negedge clk);
         start = 1'b1;          // R9: ignored while busy
         @(negedge clk);
         start = 1'b0;
      end
      t = 0;
      while (donecnt == 0 && t < 300) begin
         @(negedge clk);
         t++;
      end
      repeat (4) @(negedge clk);
      n = bw ? 3 : 4;
      ea[0] = CFG_A; ed[0] = bw ? (oldc | scfg) : exp_first(oldc, scfg);
      ea[1] = DAT_A; ed[1] = sdat;
      ea[2] = CFG_A; ed[2] = scfg;
      ea[3] = PULL_A; ed[3] = spull;
      chk("R2 single read", rdcount, 1);
      chk("R2 read address", rd_addr_err, 0);
      chk("R2 read before write", order_err, 0);
      chk(bw ? "R6 write count" : "R3 write count", wcount, n);
      for (int i = 0; i < n && i < wcount; i++) begin
         chk(bw ? "R6 write address" : "R3 write address", {24'd0, log_a[i]}, {24'd0, ea[i]});
         if (i == 0) chk(bw ? "R6 first word" : "R4 first word", log_d[i], ed[i]);
         else        chk(bw ? "R6 write data" : "R5 write data R10", log_d[i], ed[i]);
      end
      chk("R7 stalled write held", hold_err, 0);
      chk(poke ? "R9 single done" : "R8 single done", donecnt, 1);
      chk("R8 done timing", done_err, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset busy", busy, 0);
      chk("R1 reset done", done, 0);
      chk("R1 reset rd_en", rd_en, 0);
      chk("R1 reset wr_en", wr_en, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 idle outputs", {busy, done, rd_en, wr_en}, 0);
      // R4: every old/new field pair in every pin position
      for (int k = 0; k < 16; k++) begin
         logic [W-1:0] o, nw;
         for (int i = 0; i < 16; i++) begin
            int c;
            c = (i + k) % 16;
            o[2*i +: 2]  = c[3:2];
            nw[2*i +: 2] = c[1:0];
         end
         stall_on = k[0];
         run_seq(1'b0, o, nw, $urandom, $urandom, k[1] & k[2]);
      end
      stall_on = 1'b1;
      for (int r = 0; r < 10; r++)
         run_seq(1'b0, $urandom, $urandom, $urandom, $urandom, r[0]);
      // R6: narrow bank
      run_seq(1'b1, 32'h0000_FFFF, 32'hFF00_FF00, 32'h1234_5678, 32'hDEAD_BEEF, 1'b0);
      for (int r = 0; r < 6; r++)
         run_seq(1'b1, $urandom, $urandom, $urandom, $urandom, r[0]);
      stall_on = 1'b0;
      run_seq(1'b0, 32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_0000, 32'h0F0F_0F0F, 1'b1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule